// File: doc/BRIEF.md
# Mirrored Interrupt Status and IRQ Aggregator

This block keeps one interrupt-pending flag for each of two channels. Each flag is visible at two places in configuration space, a primary alias and a shared mirror byte, and both copies stay equal at all times. The pending flags follow edges on the channel level inputs. Software clears a flag by writing a one to either of its aliases, and the clear reaches both copies in the same cycle.

A per-channel block bit, loaded only through a separate mask port from the DMA register window, gates each channel. The single level-sensitive interrupt output is the OR of the unblocked pending flags and is taken from a register.

The configuration port is one aligned word of `CFG_BYTES` bytes with byte enables (8 by default, at least 2). A write is taken in the cycle that `cfg_wr_en` is high. It has no handshake and is never back-pressured. The read port is combinational. All other ports are plain control pins.

Top module: `intr_mirror`

## Requirements
- R1: While reset is held and in the first cycle after it, both pending flags, both block bits and `irq_out` are 0.
- R2: Reading the byte at offset 0x50 returns channel 0's pending flag in bit 2. Offset 0x57 returns channel 1's in bit 4. Offset 0x71 returns channel 0's in bit 2, channel 1's in bit 3, block bit 0 in bit 4 and block bit 1 in bit 5. Every other bit and byte reads 0.
- R3: When a channel level input differs from its value in the previous cycle, the channel's pending flag takes the new level at the next clock edge. Both aliases take it together.
- R4: A configuration write with a 1 in a pending-flag bit position, in an enabled byte lane, clears that channel's flag in both aliases at the next edge. This applies through either alias, including while the level is held high. A 0 in that position, or a disabled lane, leaves the flag unchanged.
- R5: If a level change and a clear for the same channel arrive in the same cycle, the level change decides the flag.
- R6: Block bits change only through the mask port, loading `mask_wr_data` at the edge where `mask_wr_en` is high. Configuration writes to offset 0x71 bits 4 and 5, or to any other bit of the three bytes, have no effect.
- R7: At every edge after reset, `irq_out` takes (pending0 AND NOT block0) OR (pending1 AND NOT block1), evaluated on the state before that edge.
- R8: One configuration write whose byte enables cover both 0x50 and 0x57 applies both clears at the same edge.
- R9: The primary and mirror copies of each channel's flag are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8-log2(CFG_BYTES) | Word index of the write |
| cfg_wr_be | input | CFG_BYTES | Byte-lane enables of the write |
| cfg_wr_data | input | 8*CFG_BYTES | Write data, lane 0 in the low byte |
| cfg_rd_addr | input | 8-log2(CFG_BYTES) | Word index of the read |
| cfg_rd_data | output | 8*CFG_BYTES | Combinational read data |
| chan_irq | input | 2 | Channel interrupt levels |
| mask_wr_en | input | 1 | Block-bit load strobe |
| mask_wr_data | input | 2 | New block bits, bit n for channel n |
| irq_out | output | 1 | Registered interrupt level |

## Verification
The bench walks every combination of channel pending pattern and block pattern. Under each, it writes each of three words: the word holding both primary aliases, the mirror word, and an unrelated neighbour. The write data sweeps the two flag bits, the lane enables, and ones fill in every other bit. The primary word tells apart clears through the primary aliases, including the dual clear of R8, and the mirror word tells apart clears through the mirror. The neighbour and the disabled lanes must show no effect, and the ones fill exposes any writable block or reserved bit. Directed steps pit a level edge against a clear in the same cycle, and clear a flag while its level stays high. After every step, both words and the interrupt are read back against an arithmetic model that includes the one-cycle lag of the interrupt.

// File: rtl/intr_mirror_pkg.sv
package intr_mirror_pkg;
  localparam int NUM_CH      = 2;
  localparam int MIRROR_OFF  = 'h71;
  localparam int MIR_PEND_B0 = 2;
  localparam int BLOCK_B0    = 4;

  // byte offset of a channel's primary alias
  function automatic int prim_off(input int ch);
    return (ch == 0) ? 'h50 : 'h57;
  endfunction

  // bit of the pending flag inside its primary byte
  function automatic int prim_bit(input int ch);
    return (ch == 0) ? 2 : 4;
  endfunction

  function automatic int mir_bit(input int ch);
    return MIR_PEND_B0 + ch;
  endfunction

  function automatic int blk_bit(input int ch);
    return BLOCK_B0 + ch;
  endfunction
endpackage

// File: rtl/intr_mirror_wdec.sv
module intr_mirror_wdec
  import intr_mirror_pkg::*;
#(
  parameter int CFG_BYTES = 8,
  localparam int LW = $clog2(CFG_BYTES),
  localparam int WA = 8 - LW
) (
  input  logic                   wr_en,
  input  logic [WA-1:0]          wr_addr,
  input  logic [CFG_BYTES-1:0]   wr_be,
  input  logic [8*CFG_BYTES-1:0] wr_data,
  output logic [NUM_CH-1:0]      clr_prim,
  output logic [NUM_CH-1:0]      clr_mir
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data, wr_be};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int PO = prim_off(c);
    localparam int PL = PO % CFG_BYTES;
    localparam int PW = PO / CFG_BYTES;
    localparam int PB = PL * 8 + prim_bit(c);
    localparam int ML = MIRROR_OFF % CFG_BYTES;
    localparam int MW = MIRROR_OFF / CFG_BYTES;
    localparam int MB = ML * 8 + mir_bit(c);

    assign clr_prim[c] = wr_en && (wr_addr == WA'(PW)) && wr_be[PL] && wr_data[PB];
    assign clr_mir[c]  = wr_en && (wr_addr == WA'(MW)) && wr_be[ML] && wr_data[MB];
  end
endmodule

// File: rtl/intr_mirror_chan.sv
module intr_mirror_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  input  logic clr_prim_in,
  input  logic clr_mir_in,
  output logic pend_prim_q,
  output logic pend_mir_q,
  output logic lvl_q
);
  logic chg;
  logic clr_any;
  logic nxt_prim;
  logic nxt_mir;

  assign chg     = lvl_in ^ lvl_q;
  assign clr_any = clr_prim_in | clr_mir_in;

  // a level edge outranks a software clear in the same cycle
  always_comb begin
    nxt_prim = pend_prim_q;
    nxt_mir  = pend_mir_q;
    if (chg) begin
      nxt_prim = lvl_in;
      nxt_mir  = lvl_in;
    end else if (clr_any) begin
      nxt_prim = 1'b0;
      nxt_mir  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q       <= 1'b0;
      pend_prim_q <= 1'b0;
      pend_mir_q  <= 1'b0;
    end else begin
      lvl_q       <= lvl_in;
      pend_prim_q <= nxt_prim;
      pend_mir_q  <= nxt_mir;
    end
  end
endmodule

// File: rtl/intr_mirror_gate.sv
module intr_mirror_gate
  import intr_mirror_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr_en,
  input  logic [NUM_CH-1:0] mask_wr_data,
  input  logic [NUM_CH-1:0] pend,
  output logic [NUM_CH-1:0] blk_q,
  output logic              irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (mask_wr_en) blk_q <= mask_wr_data;
      irq_q <= |(pend & ~blk_q);
    end
  end
endmodule

// File: rtl/intr_mirror_rdmux.sv
module intr_mirror_rdmux
  import intr_mirror_pkg::*;
#(
  parameter int CFG_BYTES = 8,
  localparam int LW = $clog2(CFG_BYTES),
  localparam int WA = 8 - LW
) (
  input  logic [WA-1:0]          rd_addr,
  input  logic [NUM_CH-1:0]      pend_prim,
  input  logic [NUM_CH-1:0]      pend_mir,
  input  logic [NUM_CH-1:0]      blk,
  output logic [8*CFG_BYTES-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    for (int lane = 0; lane < CFG_BYTES; lane++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if ({rd_addr, LW'(lane)} == 8'(prim_off(c)))
          rd_data[lane*8 + prim_bit(c)] = pend_prim[c];
        if ({rd_addr, LW'(lane)} == 8'(MIRROR_OFF)) begin
          rd_data[lane*8 + mir_bit(c)] = pend_mir[c];
          rd_data[lane*8 + blk_bit(c)] = blk[c];
        end
      end
    end
  end
endmodule

// File: rtl/intr_mirror.sv
module intr_mirror
  import intr_mirror_pkg::*;
#(
  parameter int CFG_BYTES = 8,
  localparam int LW = $clog2(CFG_BYTES),
  localparam int WA = 8 - LW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr_en,
  input  logic [WA-1:0]          cfg_wr_addr,
  input  logic [CFG_BYTES-1:0]   cfg_wr_be,
  input  logic [8*CFG_BYTES-1:0] cfg_wr_data,
  input  logic [WA-1:0]          cfg_rd_addr,
  output logic [8*CFG_BYTES-1:0] cfg_rd_data,
  input  logic [1:0]             chan_irq,
  input  logic                   mask_wr_en,
  input  logic [1:0]             mask_wr_data,
  output logic                   irq_out
);
  logic [NUM_CH-1:0] clr_prim;
  logic [NUM_CH-1:0] clr_mir;
  logic [NUM_CH-1:0] pend_prim;
  logic [NUM_CH-1:0] pend_mir;
  logic [NUM_CH-1:0] lvl_q;
  logic [NUM_CH-1:0] blk_q;

  intr_mirror_wdec #(.CFG_BYTES(CFG_BYTES)) u_wdec (
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_wr_addr),
    .wr_be   (cfg_wr_be),
    .wr_data (cfg_wr_data),
    .clr_prim(clr_prim),
    .clr_mir (clr_mir)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    intr_mirror_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_in     (chan_irq[c]),
      .clr_prim_in(clr_prim[c]),
      .clr_mir_in (clr_mir[c]),
      .pend_prim_q(pend_prim[c]),
      .pend_mir_q (pend_mir[c]),
      .lvl_q      (lvl_q[c])
    );
  end

  intr_mirror_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_wr_en  (mask_wr_en),
    .mask_wr_data(mask_wr_data),
    .pend        (pend_prim),
    .blk_q       (blk_q),
    .irq_q       (irq_out)
  );

  intr_mirror_rdmux #(.CFG_BYTES(CFG_BYTES)) u_rdmux (
    .rd_addr  (cfg_rd_addr),
    .pend_prim(pend_prim),
    .pend_mir (pend_mir),
    .blk      (blk_q),
    .rd_data  (cfg_rd_data)
  );
endmodule

// File: rtl/intr_mirror_chk.sv
module intr_mirror_chk
  import intr_mirror_pkg::*;
#(
  parameter int CFG_BYTES = 8,
  localparam int LW = $clog2(CFG_BYTES),
  localparam int WA = 8 - LW
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_wr_en,
  input logic [WA-1:0]          cfg_wr_addr,
  input logic [CFG_BYTES-1:0]   cfg_wr_be,
  input logic [8*CFG_BYTES-1:0] cfg_wr_data,
  input logic [1:0]             chan_irq,
  input logic                   mask_wr_en,
  input logic [1:0]             mask_wr_data,
  input logic                   irq_out,
  input logic [NUM_CH-1:0]      pend_prim,
  input logic [NUM_CH-1:0]      pend_mir,
  input logic [NUM_CH-1:0]      lvl_q,
  input logic [NUM_CH-1:0]      blk_q
);
  logic unused_chk_bits;
  assign unused_chk_bits = ^{cfg_wr_data, cfg_wr_be};

  // R7
  irq_follows_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_out == $past((pend_prim[0] & ~blk_q[0]) | (pend_prim[1] & ~blk_q[1])));

  // R6
  blk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> blk_q == $past(mask_wr_data));

  // R6
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_en |=> $stable(blk_q));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int PO = prim_off(c);
    localparam int PB = (PO % CFG_BYTES) * 8 + prim_bit(c);
    localparam int MB = (MIRROR_OFF % CFG_BYTES) * 8 + mir_bit(c);
    logic hit;
    assign hit = cfg_wr_en &&
      (((cfg_wr_addr == WA'(PO / CFG_BYTES)) && cfg_wr_be[PO % CFG_BYTES] && cfg_wr_data[PB]) ||
       ((cfg_wr_addr == WA'(MIRROR_OFF / CFG_BYTES)) && cfg_wr_be[MIRROR_OFF % CFG_BYTES] &&
        cfg_wr_data[MB]));

    // R9
    alias_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_prim[c] == pend_mir[c]);

    // R3
    level_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_irq[c] != lvl_q[c]) |=> pend_prim[c] == $past(chan_irq[c]));

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && chan_irq[c] == lvl_q[c]) |=> !pend_prim[c]);

    // R4
    no_hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && chan_irq[c] == lvl_q[c]) |=> $stable(pend_prim[c]));
  end
endmodule

bind intr_mirror intr_mirror_chk #(.CFG_BYTES(CFG_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_addr (cfg_wr_addr),
  .cfg_wr_be   (cfg_wr_be),
  .cfg_wr_data (cfg_wr_data),
  .chan_irq    (chan_irq),
  .mask_wr_en  (mask_wr_en),
  .mask_wr_data(mask_wr_data),
  .irq_out     (irq_out),
  .pend_prim   (pend_prim),
  .pend_mir    (pend_mir),
  .lvl_q       (lvl_q),
  .blk_q       (blk_q)
);

// File: tb/intr_mirror_bench.sv
module intr_mirror_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [4:0]  cfg_wr_addr = '0;
  logic [7:0]  cfg_wr_be = '0;
  logic [63:0] cfg_wr_data = '0;
  logic [4:0]  cfg_rd_addr = '0;
  logic [63:0] cfg_rd_data;
  logic [1:0]  chan_irq = '0;
  logic        mask_wr_en = 1'b0;
  logic [1:0]  mask_wr_data = '0;
  logic        irq_out;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [1:0] m_lvl = '0, m_pend = '0, m_blk = '0;
  logic       m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_mirror #(.CFG_BYTES(8)) u_intr_mirror (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_be(cfg_wr_be), .cfg_wr_data(cfg_wr_data), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rd_data(cfg_rd_data), .chan_irq(chan_irq), .mask_wr_en(mask_wr_en),
    .mask_wr_data(mask_wr_data), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reads word 0x50 (index 0x0A), mirror word 0x70 (0x0E), neighbour 0x58 (0x0B)
  task automatic check_state(input string ctx);
    logic [63:0] w50, w70;
    cfg_rd_addr = 5'h0A; #1 w50 = cfg_rd_data;
    chk({ctx, " R2 primary word"}, w50, (64'(m_pend[0]) << 2) | (64'(m_pend[1]) << 60));
    cfg_rd_addr = 5'h0E; #1 w70 = cfg_rd_data;
    chk({ctx, " R2/R6 mirror word"}, w70,
        (64'(m_pend[0]) << 10) | (64'(m_pend[1]) << 11) |
        (64'(m_blk[0]) << 12) | (64'(m_blk[1]) << 13));
    chk({ctx, " R9 alias coherence"}, {62'd0, w50[60], w50[2]}, {62'd0, w70[11], w70[10]});
    cfg_rd_addr = 5'h0B; #1;
    chk({ctx, " R2 unrelated word"}, cfg_rd_data, 64'd0);
    chk({ctx, " R7 irq"}, {63'd0, irq_out}, {63'd0, m_irq});
  endtask

  task automatic step(input logic [1:0] lv, input logic wr, input logic [4:0] a,
                      input logic [7:0] be, input logic [63:0] d,
                      input logic mwe, input logic [1:0] md);
    logic [1:0] clr;
    chan_irq = lv; cfg_wr_en = wr; cfg_wr_addr = a; cfg_wr_be = be; cfg_wr_data = d;
    mask_wr_en = mwe; mask_wr_data = md;
    @(posedge clk);
    clr[0] = wr && ((a == 5'h0A && be[0] && d[2])  || (a == 5'h0E && be[1] && d[10]));
    clr[1] = wr && ((a == 5'h0A && be[7] && d[60]) || (a == 5'h0E && be[1] && d[11]));
    m_irq = |(m_pend & ~m_blk);
    for (int c = 0; c < 2; c++) begin
      if (lv[c] != m_lvl[c]) m_pend[c] = lv[c];
      else if (clr[c]) m_pend[c] = 1'b0;
    end
    m_lvl = lv;
    if (mwe) m_blk = md;
    @(negedge clk);
    cfg_wr_en = 1'b0; mask_wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [4:0]  a;
    logic [7:0]  be;
    logic [63:0] d;
    int b0, b1;
    chan_irq = 2'b11;
    cfg_wr_en = 1'b1; cfg_wr_addr = 5'h0E; cfg_wr_be = '1; cfg_wr_data = '1;
    mask_wr_en = 1'b1; mask_wr_data = 2'b11;
    repeat (3) @(negedge clk);
    // R1: state held clear under reset despite active inputs
    check_state("R1 during reset");
    chan_irq = '0; cfg_wr_en = 1'b0; mask_wr_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after reset");

    // R5: level rise and clear of the same channel in one cycle
    step(2'b11, 1'b1, 5'h0E, 8'hFF, 64'h0C00, 1'b0, 2'b00);
    check_state("R5 level beats clear");
    // R4: clear while level held high, through the mirror
    step(2'b11, 1'b1, 5'h0E, 8'h02, 64'h0C00, 1'b0, 2'b00);
    check_state("R4 clear under high level");
    step(2'b11, 1'b0, 5'h00, 8'h00, 64'h0, 1'b0, 2'b00);
    check_state("R7 idle after clear");
    // R3: falling then rising edges
    step(2'b01, 1'b0, 5'h00, 8'h00, 64'h0, 1'b0, 2'b00);
    check_state("R3 ch1 fall");
    step(2'b10, 1'b0, 5'h00, 8'h00, 64'h0, 1'b0, 2'b00);
    check_state("R3 ch1 rise ch0 fall");

    // sweep: pending pattern x block pattern x target word x data pattern
    for (int lp = 0; lp < 4; lp++)
      for (int bm = 0; bm < 4; bm++)
        for (int tgt = 0; tgt < 3; tgt++)
          for (int dv = 0; dv < 16; dv++) begin
            step(2'b00, 1'b0, 5'h00, 8'h00, 64'h0, 1'b1, 2'(bm));
            check_state("R6 mask load");
            step(2'(lp), 1'b0, 5'h00, 8'h00, 64'h0, 1'b0, 2'b00);
            check_state("R3 level rise");
            a  = (tgt == 0) ? 5'h0A : (tgt == 1) ? 5'h0E : 5'h0B;
            b0 = (tgt == 1) ? 10 : 2;
            b1 = (tgt == 1) ? 11 : 60;
            d  = dv[3] ? ~((64'd1 << b0) | (64'd1 << b1)) : 64'd0;
            if (dv[0]) d[b0] = 1'b1;
            if (dv[1]) d[b1] = 1'b1;
            be = dv[2] ? 8'hFF : ((tgt == 1) ? 8'hFD : 8'h7E);
            step(2'(lp), 1'b1, a, be, d, 1'b0, 2'b00);
            check_state("R4/R8 config write");
            step(2'(lp), 1'b0, 5'h00, 8'h00, 64'h0, 1'b0, 2'b00);
            check_state("R7 settle");
          end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule